// File: doc/BRIEF.md
# Voltage/Frequency Operating-Point Transition Sequencer

This block moves a logic domain from one performance level to another. A level is one of a small set of points, indexed from slowest to fastest. Each point pairs a regulator voltage code with a clock-generator frequency code. A policy agent outside the block offers a target index through a valid/ready handshake. The sequencer then writes the regulator code and the clock-generator code in the order that keeps timing safe. Raising performance applies voltage first. Lowering performance applies frequency first.

After each regulator write, the sequencer waits a run-time count of clock cycles for the supply to settle. After each clock-generator write, it waits for the lock indication. A stall request to the surrounding peripherals stays high for the whole change. A one-cycle done pulse ends every accepted request. If lock fails to return within a run-time cycle limit, the sequencer raises a sticky error, abandons the change and keeps the previous committed index. The committed index can be read at any time. An index above the last point is treated as the last point.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, curIdx is 0, vregCode and clkgenCode hold the codes of point 0, reqReady is 1, and busy, stallReq, done and lockErr are 0.
- R2: reqReady is 1 only while the block is idle, and a request is taken in a cycle where reqValid and reqReady are both 1. Requests offered while busy are not taken; this holds even when reqValid stays high with another index until done.
- R3: Point i carries voltage code V_MIN + i*V_STEP and frequency code F_MIN + i*F_STEP, and a higher index is a faster point. Each load pulse presents the code of the target point on the same cycle.
- R4: For a faster target, vregLoad pulses two cycles after the accepting cycle, before any clkgenLoad pulse of that request.
- R5: For a slower target, clkgenLoad pulses two cycles after the accepting cycle, and any vregLoad pulse of that request comes later.
- R6: After a vregLoad pulse, the next step (clkgenLoad pulse, or done) comes max(settleCycles,1)+1 cycles later when going faster, or max(settleCycles,1) cycles later when going slower.
- R7: The lock wait starts on the clkgenLoad cycle, and pllLocked is ignored on that first cycle. Lock first seen k cycles after clkgenLoad (k at least 1) gives done at k+1 cycles after it (faster), or vregLoad at k+2 cycles after it (slower).
- R8: stallReq is 1 on every cycle from the one after acceptance up to, but not including, the done cycle of a transition. It is 0 while idle, in the done cycle, and for a request to the current point.
- R9: done is a single-cycle pulse. curIdx changes only in a done cycle, and on success it shows the target there.
- R10: A request for the point already current gives done on the cycle after acceptance, with no load pulse and no stall.
- R11: If lock is not seen by the cycle lockLimit-1 cycles after clkgenLoad, done comes lockLimit cycles after clkgenLoad. lockErr is then set and stays set until reset, and curIdx is unchanged.
- R12: busy is 1 from the cycle after acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Target request offered |
| reqIdx | input | IDX_W | Target point index (clamped to the last point) |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| settleCycles | input | CNT_W | Regulator settling wait in cycles |
| lockLimit | input | CNT_W | Lock wait limit in cycles |
| pllLocked | input | 1 | Clock generator lock indication |
| vregCode | output | VCODE_W | Voltage code to the regulator |
| vregLoad | output | 1 | One-cycle strobe: apply vregCode |
| clkgenCode | output | FCODE_W | Frequency code to the clock generator |
| clkgenLoad | output | 1 | One-cycle strobe: apply clkgenCode |
| stallReq | output | 1 | Peripheral stall request during a transition |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| lockErr | output | 1 | Sticky lock timeout flag |
| curIdx | output | IDX_W | Last successfully committed point |

## Verification
A wrong step order shows within two cycles of acceptance, as the wrong load strobe firing first. A miscounted settle or lock wait moves the next strobe or the done pulse by a fixed number of cycles, and the bench measures that gap against arithmetic built from settleCycles, the lock delay and lockLimit. A bad commit or a lost sticky error shows on curIdx or lockErr at the done cycle. A stall or busy gap shows on the exact cycle it happens, because both are checked on every cycle of every request.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_VSET,
    S_VWAIT,
    S_FSET,
    S_FWAIT,
    S_FIN
  } seq_state_t;

  typedef struct packed {
    logic latchTgt;
    logic loadV;
    logic loadF;
    logic clrCnt;
    logic commit;
    logic setErr;
  } seq_strobe_t;

endpackage

// File: rtl/dvfs_seq_dp.sv
module dvfs_seq_dp
  import dvfs_seq_pkg::*;
#(
  parameter int NUM_POINTS = 4,
  parameter int IDX_W      = 2,
  parameter int VCODE_W    = 8,
  parameter int FCODE_W    = 8,
  parameter int CNT_W      = 12,
  parameter int V_MIN      = 40,
  parameter int V_STEP     = 12,
  parameter int F_MIN      = 25,
  parameter int F_STEP     = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  seq_strobe_t        stb,
  input  logic [IDX_W-1:0]   reqIdx,
  output logic [IDX_W-1:0]   reqIdxC,
  output logic [IDX_W-1:0]   curIdx,
  output logic [CNT_W-1:0]   cnt,
  output logic [VCODE_W-1:0] vregCode,
  output logic               vregLoad,
  output logic [FCODE_W-1:0] clkgenCode,
  output logic               clkgenLoad,
  output logic               lockErr
);

  localparam logic [IDX_W:0]   LAST_IDX = (IDX_W+1)'(NUM_POINTS - 1);
  localparam logic [VCODE_W-1:0] V_RST  = VCODE_W'(V_MIN);
  localparam logic [FCODE_W-1:0] F_RST  = FCODE_W'(F_MIN);

  logic [VCODE_W-1:0] vTable [NUM_POINTS];
  logic [FCODE_W-1:0] fTable [NUM_POINTS];
  logic [IDX_W-1:0]   tgtIdx;

  // operating-point table computed from base and step
  for (genvar g = 0; g < NUM_POINTS; g++) begin : g_point
    assign vTable[g] = VCODE_W'(V_MIN + g * V_STEP);
    assign fTable[g] = FCODE_W'(F_MIN + g * F_STEP);
  end

  assign reqIdxC = ({1'b0, reqIdx} > LAST_IDX) ? LAST_IDX[IDX_W-1:0] : reqIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtIdx     <= '0;
      curIdx     <= '0;
      cnt        <= '0;
      vregCode   <= V_RST;
      vregLoad   <= 1'b0;
      clkgenCode <= F_RST;
      clkgenLoad <= 1'b0;
      lockErr    <= 1'b0;
    end else begin
      vregLoad   <= stb.loadV;
      clkgenLoad <= stb.loadF;
      if (stb.latchTgt) tgtIdx <= reqIdxC;
      if (stb.loadV)    vregCode <= vTable[tgtIdx];
      if (stb.loadF)    clkgenCode <= fTable[tgtIdx];
      if (stb.commit)   curIdx <= tgtIdx;
      if (stb.setErr)   lockErr <= 1'b1;
      if (stb.clrCnt)   cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  // R11: error flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |=> lockErr);

  // R9: committed point moves only after a commit strobe
  p_cur_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curIdx) |-> $past(stb.commit));

  // R3: voltage strobe is a single pulse
  p_vload_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    vregLoad |=> !vregLoad);

endmodule

// File: rtl/dvfs_seq_ctrl.sv
module dvfs_seq_ctrl
  import dvfs_seq_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqIdxC,
  input  logic [IDX_W-1:0] curIdx,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] settleCycles,
  input  logic [CNT_W-1:0] lockLimit,
  input  logic             pllLocked,
  output seq_strobe_t      stb,
  output logic             reqReady,
  output logic             busy,
  output logic             stallReq,
  output logic             done
);

  seq_state_t state, nextState;
  logic goingUp, goingUpNxt;
  logic accept, settleDone, lockSeen, lockExpired;

  assign accept      = reqValid && (state == S_IDLE);
  assign settleDone  = ({1'b0, cnt} + 1'b1) >= {1'b0, settleCycles};
  // first wait cycle still sees the old lock level
  assign lockSeen    = (cnt != '0) && pllLocked;
  assign lockExpired = ({1'b0, cnt} + 1'b1) >= {1'b0, lockLimit};

  always_comb begin
    nextState  = state;
    goingUpNxt = goingUp;
    stb        = '0;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          stb.latchTgt = 1'b1;
          if (reqIdxC == curIdx) begin
            nextState = S_FIN;
          end else if (reqIdxC > curIdx) begin
            goingUpNxt = 1'b1;
            nextState  = S_VSET;
          end else begin
            goingUpNxt = 1'b0;
            nextState  = S_FSET;
          end
        end
      end
      S_VSET: begin
        stb.loadV  = 1'b1;
        stb.clrCnt = 1'b1;
        nextState  = S_VWAIT;
      end
      S_VWAIT: begin
        if (settleDone) begin
          if (goingUp) begin
            nextState = S_FSET;
          end else begin
            stb.commit = 1'b1;
            nextState  = S_FIN;
          end
        end
      end
      S_FSET: begin
        stb.loadF  = 1'b1;
        stb.clrCnt = 1'b1;
        nextState  = S_FWAIT;
      end
      S_FWAIT: begin
        if (lockSeen) begin
          if (goingUp) begin
            stb.commit = 1'b1;
            nextState  = S_FIN;
          end else begin
            nextState = S_VSET;
          end
        end else if (lockExpired) begin
          stb.setErr = 1'b1;
          nextState  = S_FIN;
        end
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      goingUp <= 1'b0;
    end else begin
      state   <= nextState;
      goingUp <= goingUpNxt;
    end
  end

  assign reqReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign stallReq = (state == S_VSET) || (state == S_VWAIT) ||
                    (state == S_FSET) || (state == S_FWAIT);

  // R2: ready never overlaps a request in progress
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busy);

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: stall only inside a request
  p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> busy);

  // R12: acceptance starts busy on the next cycle
  p_busy_accept_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_seq_pkg::*;
#(
  parameter int NUM_POINTS = 4,
  parameter int IDX_W      = $clog2(NUM_POINTS),
  parameter int VCODE_W    = 8,
  parameter int FCODE_W    = 8,
  parameter int CNT_W      = 12,
  parameter int V_MIN      = 40,
  parameter int V_STEP     = 12,
  parameter int F_MIN      = 25,
  parameter int F_STEP     = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [IDX_W-1:0]   reqIdx,
  output logic               reqReady,
  input  logic [CNT_W-1:0]   settleCycles,
  input  logic [CNT_W-1:0]   lockLimit,
  input  logic               pllLocked,
  output logic [VCODE_W-1:0] vregCode,
  output logic               vregLoad,
  output logic [FCODE_W-1:0] clkgenCode,
  output logic               clkgenLoad,
  output logic               stallReq,
  output logic               busy,
  output logic               done,
  output logic               lockErr,
  output logic [IDX_W-1:0]   curIdx
);

  seq_strobe_t      stb;
  logic [IDX_W-1:0] reqIdxC;
  logic [CNT_W-1:0] cnt;

  dvfs_seq_ctrl #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqIdxC      (reqIdxC),
    .curIdx       (curIdx),
    .cnt          (cnt),
    .settleCycles (settleCycles),
    .lockLimit    (lockLimit),
    .pllLocked    (pllLocked),
    .stb          (stb),
    .reqReady     (reqReady),
    .busy         (busy),
    .stallReq     (stallReq),
    .done         (done)
  );

  dvfs_seq_dp #(
    .NUM_POINTS (NUM_POINTS),
    .IDX_W      (IDX_W),
    .VCODE_W    (VCODE_W),
    .FCODE_W    (FCODE_W),
    .CNT_W      (CNT_W),
    .V_MIN      (V_MIN),
    .V_STEP     (V_STEP),
    .F_MIN      (F_MIN),
    .F_STEP     (F_STEP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqIdx     (reqIdx),
    .reqIdxC    (reqIdxC),
    .curIdx     (curIdx),
    .cnt        (cnt),
    .vregCode   (vregCode),
    .vregLoad   (vregLoad),
    .clkgenCode (clkgenCode),
    .clkgenLoad (clkgenLoad),
    .lockErr    (lockErr)
  );

  // R4: voltage is applied only under stall
  p_vload_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    vregLoad |-> stallReq);

  // R5: frequency is applied only under stall
  p_fload_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    clkgenLoad |-> stallReq);

  // R9: committed point becomes visible in the done cycle
  p_cur_at_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curIdx) |-> done);

  // R4: the two strobes never coincide
  p_no_dual_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(vregLoad && clkgenLoad));

endmodule

// File: tb/test_dvfs_seq.sv
module test_dvfs_seq;

  localparam int NP = 4;
  localparam int IW = 2;
  localparam int VW = 8;
  localparam int FW = 8;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          reqValid = 1'b0;
  logic [IW-1:0] reqIdx = '0;
  logic          reqReady;
  logic [CW-1:0] settleCycles = '0;
  logic [CW-1:0] lockLimit = '0;
  logic          pllLocked = 1'b1;
  logic [VW-1:0] vregCode;
  logic          vregLoad;
  logic [FW-1:0] clkgenCode;
  logic          clkgenLoad;
  logic          stallReq, busy, done, lockErr;
  logic [IW-1:0] curIdx;

  dvfs_seq #(.NUM_POINTS(NP), .IDX_W(IW), .VCODE_W(VW), .FCODE_W(FW), .CNT_W(CW))
  i_dvfs_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIdx(reqIdx), .reqReady(reqReady),
    .settleCycles(settleCycles), .lockLimit(lockLimit), .pllLocked(pllLocked),
    .vregCode(vregCode), .vregLoad(vregLoad), .clkgenCode(clkgenCode),
    .clkgenLoad(clkgenLoad), .stallReq(stallReq), .busy(busy), .done(done),
    .lockErr(lockErr), .curIdx(curIdx)
  );

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // clock generator model: load drops lock, relocks lockDelay edges later (0 = never drops)
  int lockDelay = 1;
  int pcnt = 0;
  always @(posedge clk) begin
    if (clkgenLoad && lockDelay > 0) begin
      pllLocked <= 1'b0;
      pcnt <= lockDelay;
    end else if (pcnt > 0) begin
      pcnt <= pcnt - 1;
      if (pcnt == 1) pllLocked <= 1'b1;
    end
  end

  // per-request monitor
  int tV, tF, tD, nV, nF, badStall, badBusy, accCyc, expStall;
  bit active = 1'b0;
  always @(negedge clk) begin
    if (vregLoad) begin nV++; tV = cyc; end
    if (clkgenLoad) begin nF++; tF = cyc; end
    if (done && tD < 0) tD = cyc;
    if (active && cyc > accCyc) begin
      if (stallReq != (done ? 1'b0 : expStall[0])) badStall++;
      if (!busy || reqReady) badBusy++;
    end
  end

  int expCur = 0;
  int expVc, expFc;
  bit expErr = 1'b0;

  function automatic int vOf(int i); return 40 + 12 * i; endfunction
  function automatic int fOf(int i); return 25 + 25 * i; endfunction

  task automatic chkEq(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    chkEq({tag, " R1 curIdx"}, int'(curIdx), 0);
    chkEq({tag, " R1 vregCode"}, int'(vregCode), vOf(0));
    chkEq({tag, " R1 clkgenCode"}, int'(clkgenCode), fOf(0));
    chkEq({tag, " R1 reqReady"}, int'(reqReady), 1);
    chkEq({tag, " R1 busy/stall/done"}, int'({busy, stallReq, done}), 0);
    chkEq({tag, " R1 lockErr"}, int'(lockErr), 0);
  endtask

  task automatic req(input int to, input int s, input int d, input int l);
    int sEff;
    bit same, up, tmo;
    sEff = (s < 1) ? 1 : s;
    same = (to == expCur);
    up   = (to > expCur);
    tmo  = !same && (d >= l - 1);
    @(negedge clk);
    settleCycles = CW'(s);
    lockLimit = CW'(l);
    lockDelay = d;
    nV = 0; nF = 0; tV = -1; tF = -1; tD = -1;
    badStall = 0; badBusy = 0;
    expStall = same ? 0 : 1;
    accCyc = cyc;
    active = 1'b1;
    chkEq("R2 ready when idle", int'(reqReady), 1);
    reqValid = 1'b1;
    reqIdx = IW'(to);
    @(negedge clk);
    reqIdx = IW'((to + 1) % NP);  // held offer while busy must be refused
    while (!done) @(negedge clk);
    reqValid = 1'b0;
    #1;
    active = 1'b0;
    if (same) begin
      chkEq("R10 same-point done cycle", tD - accCyc, 1);
      chkEq("R10 no load pulses", nV + nF, 0);
    end else if (up) begin
      chkEq("R4 vregLoad after accept", tV - accCyc, 2);
      chkEq("R6 settle before clkgenLoad", tF - tV, sEff + 1);
      chkEq("R3 one clkgenLoad", nF, 1);
      if (tmo) chkEq("R11 timeout done", tD - tF, l);
      else     chkEq("R7 lock wait up", tD - tF, d + 2);
      chkEq("R2 one vregLoad", nV, 1);
    end else begin
      chkEq("R5 clkgenLoad after accept", tF - accCyc, 2);
      chkEq("R3 one clkgenLoad", nF, 1);
      if (tmo) begin
        chkEq("R11 timeout done", tD - tF, l);
        chkEq("R11 no vregLoad after timeout", nV, 0);
      end else begin
        chkEq("R7 lock wait down", tV - tF, d + 3);
        chkEq("R6 settle before done", tD - tV, sEff);
        chkEq("R2 one vregLoad", nV, 1);
      end
    end
    if (!same) begin
      expFc = fOf(to);
      if (up || !tmo) expVc = vOf(to);
      if (!tmo) expCur = to;
      else expErr = 1'b1;
    end
    chkEq("R9 curIdx after done", int'(curIdx), expCur);
    chkEq("R3 vregCode", int'(vregCode), expVc);
    chkEq("R3 clkgenCode", int'(clkgenCode), expFc);
    chkEq("R11 lockErr", int'(lockErr), int'(expErr));
    chkEq("R8 stall cycles wrong", badStall, 0);
    chkEq("R12 busy/ready cycles wrong", badBusy, 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int sv[3];
    int dv[3];
    sv = '{0, 1, 3};
    dv = '{0, 1, 3};
    expVc = vOf(0);
    expFc = fOf(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("reset");
    for (int si = 0; si < 3; si++) begin
      for (int di = 0; di < 3; di++) begin
        for (int f = 0; f < NP; f++) begin
          for (int t = 0; t < NP; t++) begin
            req(f, sv[si], dv[di], 16);
            req(t, sv[si], dv[di], 16);
          end
        end
      end
    end
    // lock timeout, slower target
    req(0, 3, 40, 6);
    req(expCur == 0 ? 2 : 0, 2, 40, 5);
    // success afterwards keeps the sticky flag
    req(expCur == 1 ? 3 : 1, 1, 2, 16);
    req(expCur, 1, 2, 16);
    // faster target with lock limit 1 times out at once
    req(0, 1, 1, 16);
    req(2, 2, 1, 1);
    // reset clears everything
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expCur = 0; expVc = vOf(0); expFc = fOf(0); expErr = 1'b0;
    @(negedge clk);
    checkIdle("second reset");
    req(3, 2, 2, 16);
    req(1, 0, 1, 16);
    summary();
    $finish;
  end

endmodule